// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line). It gives an external bus master access to a byte-wide register space through a 16-bit pointer. Both bus lines are sampled on the system clock. The block finds start and stop conditions and compares the first byte of each transaction with its own 7-bit device address. It then either receives a two-byte register address followed by data bytes, or returns data bytes starting at the current pointer. The data line is pulled low only through an output enable. Board-level logic turns that enable into an open-drain driver.

Facing the core is a plain synchronous register-file port: an address, write data, a one-cycle write strobe and a read-data input. The read-data input may lag the address by up to two system cycles. The pointer survives between transactions, so a master can issue a read with no address phase and continue where the last access stopped. Each byte transferred in either direction advances the pointer by one.

Top module: `twi_regslave`

## Requirements
- R1: After reset the data-line enable and the write strobe are low, and the register pointer is 16'h0000, so a read with no address phase first returns the byte at address 0.
- R2: A first byte whose upper seven bits equal the device address is acknowledged by pulling the data line low during the ninth clock. For any other address the data line stays released and every later byte goes unacknowledged and unwritten until the next start or stop. The pointer is left unchanged.
- R3: In a write (direction bit 0), the second byte becomes pointer bits [15:8] and the third becomes bits [7:0]. Each following byte is written at the pointer with a single-cycle write strobe, and every byte is acknowledged.
- R4: A write burst of L data bytes that starts at pointer M writes addresses M through M+L-1 in order and leaves the pointer at M+L.
- R5: In a read (direction bit 1), the slave returns the byte at the current pointer, most significant bit first. It changes the data line only while the clock line is low.
- R6: During a read, a low acknowledge from the master makes the slave send the next byte. A high acknowledge ends the read: the slave stops driving until the next start. Every byte sent advances the pointer, including the last one.
- R7: The pointer keeps its value across stop conditions, so a later address-less read resumes from the location after the last byte transferred.
- R8: A repeated start at any point puts the parser back to expecting a device-address byte and keeps the pointer value.
- R9: The pointer wraps from 16'hFFFF to 16'h0000 when it is incremented.
- R10: After a stop, clock pulses without a new start are ignored: no acknowledge and no write strobe.
- R11: A start is a falling data line while the clock line is high, and a stop is a rising data line while the clock line is high. Data-line changes while the clock line is low are never taken as a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| reg_addr | output | 16 | Register-file address (follows the pointer) |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write strobe, one cycle per byte |
| reg_rdata | input | 8 | Register-file read data for reg_addr |

## Verification
On the ninth rising clock edge of the last byte of a read, two things happen together. The pointer advances for the byte just sent, and the master's high acknowledge ends the transaction. The bench sets this up by ending a two-byte read with a not-acknowledge and then clocking one more byte without a start. It checks that the bus reads back all ones, which means the slave stays silent. A fresh address-less read must then return the byte after the last one sent. If the pointer step were lost or applied twice, the returned byte would not match.

// File: rtl/twi_regslave_pkg.sv
package twi_regslave_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_PHI,
    PH_PLO,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_reg_ptr.sv
module twi_reg_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          inc,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] ptr
);
  localparam int HI_W = AW - 8;
  localparam logic [AW-1:0] PTR_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld_hi) begin
      ptr[AW-1:8] <= byte_in[HI_W-1:0];
    end else if (ld_lo) begin
      ptr[7:0] <= byte_in;
    end else if (inc) begin
      ptr <= ptr + 1'b1;
    end
  end

  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_hi && !ld_lo && ptr == PTR_MAX) |=> (ptr == '0));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld_hi && !ld_lo) |=> $stable(ptr));
endmodule

// File: rtl/twi_frame_fsm.sv
module twi_frame_fsm
  import twi_regslave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       ld_hi,
  output logic       ld_lo,
  output logic       ptr_inc,
  output logic       wr_stb,
  output logic [7:0] rx_byte
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] LAST_BIT = 4'd7;

  phase_t     phase;
  phase_t     next_ph;
  logic [3:0] cnt;
  logic       rw;
  logic       frame_end;
  logic [7:0] rx;
  logic [7:0] tx;

  // phase entered at the end of an acknowledged byte
  always_comb begin
    unique case (phase)
      PH_DEV:  next_ph = rw ? PH_RDAT : PH_PHI;
      PH_PHI:  next_ph = PH_PLO;
      PH_PLO:  next_ph = PH_WDAT;
      PH_WDAT: next_ph = PH_WDAT;
      PH_RDAT: next_ph = PH_RDAT;
      default: next_ph = phase;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      rw        <= 1'b0;
      frame_end <= 1'b0;
      rx        <= '0;
      tx        <= '0;
      sda_oe    <= 1'b0;
      ld_hi     <= 1'b0;
      ld_lo     <= 1'b0;
      ptr_inc   <= 1'b0;
      wr_stb    <= 1'b0;
    end else begin
      ld_hi   <= 1'b0;
      ld_lo   <= 1'b0;
      ptr_inc <= 1'b0;
      wr_stb  <= 1'b0;
      if (stop_det) begin
        phase     <= PH_IDLE;
        sda_oe    <= 1'b0;
        cnt       <= '0;
        frame_end <= 1'b0;
      end else if (start_det) begin
        phase     <= PH_DEV;
        sda_oe    <= 1'b0;
        cnt       <= '0;
        frame_end <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_SKIP) begin
        if (scl_rise) begin
          if (cnt == ACK_SLOT) begin
            cnt       <= '0;
            frame_end <= 1'b1;
            if (phase == PH_RDAT) begin
              ptr_inc <= 1'b1;
              if (sda_s) phase <= PH_SKIP;
            end
          end else begin
            cnt <= cnt + 4'd1;
            rx  <= {rx[6:0], sda_s};
            if (cnt == LAST_BIT) begin
              unique case (phase)
                PH_DEV: begin
                  if (rx[6:0] == DEV_ADDR) rw <= sda_s;
                  else phase <= PH_SKIP;
                end
                PH_PHI:  ld_hi <= 1'b1;
                PH_PLO:  ld_lo <= 1'b1;
                PH_WDAT: begin
                  wr_stb  <= 1'b1;
                  ptr_inc <= 1'b1;
                end
                default: ;
              endcase
            end
          end
        end else if (scl_fall) begin
          if (frame_end) begin
            frame_end <= 1'b0;
            phase     <= next_ph;
            if (next_ph == PH_RDAT) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (cnt == ACK_SLOT) begin
            sda_oe <= (phase != PH_RDAT);
          end else if (phase == PH_RDAT && cnt != 4'd0) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end

  assign rx_byte = rx;

  assert_released_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_oe);

  assert_drive_while_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  assert_restart_rearms_R8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (phase == PH_DEV && cnt == 4'd0));
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave #(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         AW          = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ld_hi, ld_lo, ptr_inc, wr_stb;
  logic [7:0]    rx_byte;
  logic [AW-1:0] ptr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_frame_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_byte(reg_rdata),
    .sda_oe(sda_oe), .ld_hi(ld_hi), .ld_lo(ld_lo), .ptr_inc(ptr_inc),
    .wr_stb(wr_stb), .rx_byte(rx_byte)
  );

  twi_reg_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .ld_hi(ld_hi), .ld_lo(ld_lo), .inc(ptr_inc),
    .byte_in(rx_byte), .ptr(ptr)
  );

  // the strobe meets the pre-increment pointer value
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_addr  <= ptr;
      reg_wdata <= rx_byte;
      reg_we    <= wr_stb;
    end
  end

  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_we_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + 1'b1));
endmodule

// File: tb/test_twi_regslave.sv
module test_twi_regslave;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int H = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_we;
  logic [7:0]  reg_rdata;
  logic        sda_bus;

  int errors = 0;
  int checks = 0;

  logic [7:0]  mem     [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] wl_addr [32];
  logic [7:0]  wl_data [32];
  int          wcnt = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twi_regslave #(.DEV_ADDR(DEV)) i_twi_regslave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
  end

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;
    reg_rdata <= mem[reg_addr[7:0]];
    if (!rst && reg_we && wcnt < 32) begin
      wl_addr[wcnt] <= reg_addr;
      wl_data[wcnt] <= reg_wdata;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b0; hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hp();
    scl_m = 1'b1; hp();
    s = sda_bus;
    scl_m = 1'b0;
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input bit more, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(!more, s);
  endtask

  // R1: reset state
  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 we after reset", reg_we, 0);
    chk(reg_addr == 16'h0, "R1 addr after reset", reg_addr, 0);
  endtask

  // R1 R5: address-less read right after reset starts at 0
  task automatic t_read_after_reset();
    logic a; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk(a == 1'b0, "R2 address ack on read", a, 0);
    recv_byte(1'b0, d);
    chk(d == exp_mem[0], "R1 R5 first read at pointer 0", d, exp_mem[0]);
    bus_stop();
  endtask

  // R3 R11: single write with data-line toggles while clock low
  task automatic t_single_write();
    logic a0, a1, a2, a3; int base;
    base = wcnt;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte(8'h12, a1);
    send_byte(8'h34, a2);
    for (int k = 0; k < 3; k++) begin
      sda_m = 1'b0; hp();
      sda_m = 1'b1; hp();
    end
    send_byte(8'h77, a3);
    bus_stop();
    chk({a0, a1, a2, a3} == 4'b0, "R3 all bytes acknowledged", {a0, a1, a2, a3}, 0);
    chk(wcnt == base + 1, "R3 one write strobe", wcnt - base, 1);
    chk(wl_addr[base] == 16'h1234, "R3 write address hi then lo", wl_addr[base], 16'h1234);
    chk(wl_data[base] == 8'h77, "R11 R3 write data", wl_data[base], 8'h77);
  endtask

  // R4: burst write
  task automatic t_burst_write();
    logic a; int base;
    logic [7:0] v [3];
    v[0] = 8'h11; v[1] = 8'h22; v[2] = 8'h33;
    base = wcnt;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    for (int k = 0; k < 3; k++) send_byte(v[k], a);
    bus_stop();
    chk(wcnt == base + 3, "R4 burst strobes", wcnt - base, 3);
    for (int k = 0; k < 3; k++) begin
      chk(wl_addr[base+k] == 16'h0040 + 16'(k), "R4 burst address", wl_addr[base+k], 16'h0040 + k);
      chk(wl_data[base+k] == v[k], "R4 burst data", wl_data[base+k], v[k]);
      exp_mem[8'h40 + k] = v[k];
    end
  endtask

  // R6 R7: sequential read, NACK end, then resume
  task automatic t_read_resume();
    logic a; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, d);
    chk(d == exp_mem[8'h43], "R7 read resumes after burst", d, exp_mem[8'h43]);
    recv_byte(1'b0, d);
    chk(d == exp_mem[8'h44], "R6 second byte after master ack", d, exp_mem[8'h44]);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R6 silent after not-acknowledge", d, 8'hFF);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d);
    chk(d == exp_mem[8'h45], "R6 R7 last byte advanced pointer", d, exp_mem[8'h45]);
    bus_stop();
  endtask

  // R8: repeated start keeps the freshly loaded pointer
  task automatic t_repeated_start();
    logic a; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk(a == 1'b0, "R8 address ack after repeated start", a, 0);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, d);
      chk(d == exp_mem[8'h40 + k], "R8 R5 read after repeated start", d, exp_mem[8'h40 + k]);
    end
    bus_stop();
  endtask

  // R2: foreign address is ignored
  task automatic t_mismatch();
    logic a; logic [7:0] d; int base;
    base = wcnt;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    chk(a == 1'b1, "R2 no ack for other address", a, 1);
    send_byte(8'h00, a);
    send_byte(8'h50, a);
    send_byte(8'h99, a);
    chk(a == 1'b1, "R2 later bytes unacknowledged", a, 1);
    bus_stop();
    chk(wcnt == base, "R2 no write for other address", wcnt - base, 0);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d);
    chk(d == exp_mem[8'h43], "R2 pointer untouched", d, exp_mem[8'h43]);
    bus_stop();
  endtask

  // R10: clocking after stop without a start
  task automatic t_no_start();
    logic a; logic [7:0] d; int base;
    base = wcnt;
    scl_m = 1'b0; hp();
    send_byte({DEV, 1'b0}, a);
    chk(a == 1'b1, "R10 no ack without start", a, 1);
    send_byte(8'h55, a);
    chk(wcnt == base, "R10 no write without start", wcnt - base, 0);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d);
    chk(d == exp_mem[8'h44], "R10 pointer untouched", d, exp_mem[8'h44]);
    bus_stop();
  endtask

  // R9: pointer wrap
  task automatic t_wrap();
    logic a; logic [7:0] d; int base;
    base = wcnt;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'hFF, a);
    send_byte(8'hFF, a);
    send_byte(8'hA1, a);
    send_byte(8'hA2, a);
    bus_stop();
    exp_mem[8'hFF] = 8'hA1;
    exp_mem[8'h00] = 8'hA2;
    chk(wl_addr[base] == 16'hFFFF, "R9 top address", wl_addr[base], 16'hFFFF);
    chk(wl_addr[base+1] == 16'h0000, "R9 wrapped address", wl_addr[base+1], 0);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d);
    chk(d == exp_mem[8'h01], "R9 pointer after wrap", d, exp_mem[8'h01]);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_read_after_reset();
    t_single_write();
    t_burst_write();
    t_read_resume();
    t_repeated_start();
    t_mismatch();
    t_no_start();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule